// File: doc/BRIEF.md
# Debug Power and Reset Request Register

This block is a single 32-bit control word in a debug register bank. An external debugger reaches it through a simple bus port. Through it the debugger can ask the power controller to bring the core up. It can ask that a later core powerdown be emulated rather than carried out. It can also ask the reset controller for a warm reset. The block decodes the word's address and keeps the two persistent request bits. It decides, from the lock, authentication and core-power status inputs, whether each field may be read or written. It drives the three request lines to the power and reset controllers.

The two persistent bits sit in different power domains. The power-up request belongs to the always-on debug domain: only the external debug reset clears it, and it stays usable while the core is off. The no-powerdown request belongs to the core domain: a cold reset reloads it from the power-up request, and warm and debug resets leave it alone. The warm reset request is not stored. A permitted write of 1 to it produces a single-cycle pulse. All three resets are active low and sampled on the clock edge.

Top module: `dbg_pwr_rst_ctl`

## Requirements
- R1: The word answers only at address 0x310. Its layout is bit 0 = no-powerdown request, bit 1 = warm reset request, bit 3 = power-up request. A read at any other address returns 0, and a write at any other address changes no state and produces no pulse.
- R2: Bit 2 and bits 31:4 always read 0, and writing them has no effect.
- R3: The power-up request bit (bit 3) is cleared only by the external debug reset; cold and warm resets leave it unchanged. It can be read and written while the core is unpowered.
- R4: While the cold reset is asserted, the no-powerdown bit (bit 0) loads the value the power-up bit held before that edge. Warm reset and external debug reset leave bit 0 unchanged.
- R5: Bit 1 always reads 0. A permitted write with bit 1 = 1 raises warm_rst_req_o for exactly the one cycle after the write edge. A write on an edge where the warm or cold reset is asserted gives no pulse.
- R6: A write of 1 to bit 1 gives no pulse if the core is unpowered, double lock is set, OS lock is set, software lock is set, or invasive debug is not enabled.
- R7: When the core is unpowered, or double lock or OS lock is set, bit 0 reads as 0 and writes to it are ignored.
- R8: While software lock is set, bits 0 and 3 are read-only: writes leave them unchanged, and they still read their stored values.
- R9: The invasive-debug enable input does not affect writes to bits 0 and 3.
- R10: pwrup_req_o always equals the stored bit 3 and no_pwrdn_o always equals the stored bit 0, even while bit 0 reads as 0.
- R11: bus_rdata is combinational and non-zero only in a cycle with bus_valid high, bus_write low and address 0x310.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_cold_rst_n | input | 1 | Cold reset of the core domain, active low, synchronous |
| core_warm_rst_n | input | 1 | Warm reset of the core domain, active low, synchronous |
| dbg_ext_rst_n | input | 1 | External debug reset of the debug domain, active low, synchronous |
| core_powered | input | 1 | Core power domain is on |
| lock_double | input | 1 | Double lock status |
| lock_os | input | 1 | OS lock status |
| lock_sw | input | 1 | Software lock status for this access |
| invasive_dbg_en | input | 1 | Invasive debug is authenticated |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the debug bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pwrup_req_o | output | 1 | Core power-up request to the power controller |
| no_pwrdn_o | output | 1 | Emulate-powerdown request to the power controller |
| warm_rst_req_o | output | 1 | One-cycle warm reset request pulse |

## Verification
The main sweep covers all 32 combinations of core power, double lock, OS lock, software lock and authentication. Each combination is tried with all 16 low-nibble write patterns, and the reserved bits are always set in the write data. Before each write, the stored bits are loaded with the complement of the pattern to be written. An update that should happen therefore flips the value, and a write that is wrongly blocked or wrongly allowed is always visible. Separating the status inputs tells apart the gate for each field: software lock freezes both persistent bits, power or lock loss hides and freezes only bit 0, and authentication gates only the pulse. Directed sequences apply each reset on its own, so that a reset reaching the wrong domain shows up. Further sequences cover wrong-address writes, an idle read, and a write that coincides with warm reset.

// File: rtl/dprc_pkg.sv
package dprc_pkg;

  // Bit positions inside the control word (software visible layout)
  localparam int unsigned NPD_BIT   = 0;
  localparam int unsigned WRQ_BIT   = 1;
  localparam int unsigned PWRUP_BIT = 3;
  localparam int unsigned FIELD_W   = 4;

  // No-powerdown field is hidden (reads 0, ignores writes)
  function automatic logic npd_hidden(input logic powered, input logic dlock,
                                      input logic oslock);
    return !powered || dlock || oslock;
  endfunction

  // Warm reset request is accepted
  function automatic logic warm_permitted(input logic powered, input logic dlock,
                                          input logic oslock, input logic swlock,
                                          input logic inv_en);
    return powered && !dlock && !oslock && !swlock && inv_en;
  endfunction

  // Visible low nibble of the word; all other bits are zero
  function automatic logic [FIELD_W-1:0] read_nibble(input logic pwrup, input logic npd,
                                                     input logic hidden);
    logic [FIELD_W-1:0] r;
    r            = '0;
    r[PWRUP_BIT] = pwrup;
    r[NPD_BIT]   = npd & !hidden;
    return r;
  endfunction

endpackage

// File: rtl/dprc_decode.sv
module dprc_decode #(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h310
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wd_npd,
  input  logic              wd_wrq,
  input  logic              core_powered,
  input  logic              lock_double,
  input  logic              lock_os,
  input  logic              lock_sw,
  input  logic              invasive_dbg_en,
  output logic              rd_hit,
  output logic              npd_hide,
  output logic              pwrup_we,
  output logic              npd_we,
  output logic              warm_fire
);
  import dprc_pkg::*;

  logic addr_hit;
  logic wr_hit;

  assign addr_hit  = bus_valid && (bus_addr == REG_OFFSET);
  assign wr_hit    = addr_hit && bus_write;
  assign rd_hit    = addr_hit && !bus_write;
  assign npd_hide  = npd_hidden(core_powered, lock_double, lock_os);

  // Authentication status deliberately absent from the two persistent bits
  assign pwrup_we  = wr_hit && !lock_sw;
  assign npd_we    = wr_hit && !lock_sw && !npd_hide;
  assign warm_fire = wr_hit && wd_wrq &&
                     warm_permitted(core_powered, lock_double, lock_os, lock_sw,
                                    invasive_dbg_en);
  // wd_npd is the value written, consumed by the storage; decode only gates
  logic unused_wd;
  assign unused_wd = wd_npd;
endmodule

// File: rtl/dprc_fields.sv
module dprc_fields #(
  parameter bit WARM_REQ_EN = 1'b1
) (
  input  logic clk,
  input  logic core_cold_rst_n,
  input  logic core_warm_rst_n,
  input  logic dbg_ext_rst_n,
  input  logic pwrup_we,
  input  logic pwrup_wval,
  input  logic npd_we,
  input  logic npd_wval,
  input  logic warm_fire,
  output logic pwrup_q,
  output logic npd_q,
  output logic warm_q
);

  // Debug power domain: only the external debug reset reaches it
  always_ff @(posedge clk) begin
    if (!dbg_ext_rst_n)  pwrup_q <= 1'b0;
    else if (pwrup_we)   pwrup_q <= pwrup_wval;
  end

  // Core power domain: cold reset copies the power-up request
  always_ff @(posedge clk) begin
    if (!core_cold_rst_n) npd_q <= pwrup_q;
    else if (npd_we)      npd_q <= npd_wval;
  end

  generate
    if (WARM_REQ_EN) begin : g_warm
      always_ff @(posedge clk) begin
        if (!core_cold_rst_n || !core_warm_rst_n) warm_q <= 1'b0;
        else                                      warm_q <= warm_fire;
      end
    end else begin : g_no_warm
      logic unused_fire;
      assign unused_fire = warm_fire;
      assign warm_q      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dbg_pwr_rst_ctl.sv
module dbg_pwr_rst_ctl #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h310,
  parameter bit          WARM_REQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              core_cold_rst_n,
  input  logic              core_warm_rst_n,
  input  logic              dbg_ext_rst_n,
  input  logic              core_powered,
  input  logic              lock_double,
  input  logic              lock_os,
  input  logic              lock_sw,
  input  logic              invasive_dbg_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwrup_req_o,
  output logic              no_pwrdn_o,
  output logic              warm_rst_req_o
);
  import dprc_pkg::*;

  localparam int unsigned PAD_W = DATA_W - FIELD_W;

  // Named internal events (observed by the checker)
  logic rd_hit, npd_hide, pwrup_we, npd_we, warm_fire;
  logic pwrup_q, npd_q, warm_q;

  dprc_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_decode (
    .bus_valid       (bus_valid),
    .bus_write       (bus_write),
    .bus_addr        (bus_addr),
    .wd_npd          (bus_wdata[NPD_BIT]),
    .wd_wrq          (bus_wdata[WRQ_BIT]),
    .core_powered    (core_powered),
    .lock_double     (lock_double),
    .lock_os         (lock_os),
    .lock_sw         (lock_sw),
    .invasive_dbg_en (invasive_dbg_en),
    .rd_hit          (rd_hit),
    .npd_hide        (npd_hide),
    .pwrup_we        (pwrup_we),
    .npd_we          (npd_we),
    .warm_fire       (warm_fire)
  );

  dprc_fields #(.WARM_REQ_EN(WARM_REQ_EN)) u_fields (
    .clk             (clk),
    .core_cold_rst_n (core_cold_rst_n),
    .core_warm_rst_n (core_warm_rst_n),
    .dbg_ext_rst_n   (dbg_ext_rst_n),
    .pwrup_we        (pwrup_we),
    .pwrup_wval      (bus_wdata[PWRUP_BIT]),
    .npd_we          (npd_we),
    .npd_wval        (bus_wdata[NPD_BIT]),
    .warm_fire       (warm_fire),
    .pwrup_q         (pwrup_q),
    .npd_q           (npd_q),
    .warm_q          (warm_q)
  );

  // Reserved write bits are dropped here
  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:FIELD_W], bus_wdata[2]};

  assign bus_rdata = rd_hit ? {{PAD_W{1'b0}}, read_nibble(pwrup_q, npd_q, npd_hide)}
                            : '0;

  assign pwrup_req_o    = pwrup_q;
  assign no_pwrdn_o     = npd_q;
  assign warm_rst_req_o = warm_q;
endmodule

// File: rtl/dprc_checker.sv
module dprc_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h310
) (
  input logic              clk,
  input logic              core_cold_rst_n,
  input logic              core_warm_rst_n,
  input logic              dbg_ext_rst_n,
  input logic              core_powered,
  input logic              lock_double,
  input logic              lock_os,
  input logic              lock_sw,
  input logic              invasive_dbg_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_wrq,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwrup_req_o,
  input logic              no_pwrdn_o,
  input logic              warm_rst_req_o,
  input logic              pwrup_we,
  input logic              warm_fire
);
  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  AST_MISS_READS_ZERO: assert property (@(posedge clk)
    (bus_valid && bus_addr != REG_OFFSET) |-> bus_rdata == '0); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk)
    bus_rdata[2] == 1'b0 && bus_rdata[1] == 1'b0 && bus_rdata[DATA_W-1:4] == '0); // R2

  AST_PWRUP_HOLD: assert property (@(posedge clk) disable iff (!dbg_ext_rst_n)
    !pwrup_we |=> $stable(pwrup_req_o)); // R3

  AST_COLD_LOAD: assert property (@(posedge clk)
    (past_valid && $past(!core_cold_rst_n)) |-> no_pwrdn_o == $past(pwrup_req_o)); // R4

  AST_PULSE_SOURCE: assert property (@(posedge clk)
    disable iff (!core_cold_rst_n || !core_warm_rst_n)
    warm_rst_req_o |-> $past(warm_fire)); // R5

  AST_PULSE_GATE: assert property (@(posedge clk)
    disable iff (!core_cold_rst_n || !core_warm_rst_n)
    warm_rst_req_o |-> $past(bus_valid && bus_write && bus_addr == REG_OFFSET && wd_wrq &&
                             core_powered && !lock_double && !lock_os && !lock_sw &&
                             invasive_dbg_en)); // R6

  AST_NPD_HIDDEN: assert property (@(posedge clk)
    ((!core_powered || lock_double || lock_os) && bus_valid && !bus_write &&
     bus_addr == REG_OFFSET) |-> bus_rdata[0] == 1'b0); // R7

  AST_SWLOCK_FREEZE: assert property (@(posedge clk)
    disable iff (!core_cold_rst_n || !dbg_ext_rst_n)
    lock_sw |=> ($stable(no_pwrdn_o) && $stable(pwrup_req_o))); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk)
    !(bus_valid && !bus_write) |-> bus_rdata == '0); // R11
endmodule

bind dbg_pwr_rst_ctl dprc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
) i_dprc_checker (
  .clk             (clk),
  .core_cold_rst_n (core_cold_rst_n),
  .core_warm_rst_n (core_warm_rst_n),
  .dbg_ext_rst_n   (dbg_ext_rst_n),
  .core_powered    (core_powered),
  .lock_double     (lock_double),
  .lock_os         (lock_os),
  .lock_sw         (lock_sw),
  .invasive_dbg_en (invasive_dbg_en),
  .bus_valid       (bus_valid),
  .bus_write       (bus_write),
  .bus_addr        (bus_addr),
  .wd_wrq          (bus_wdata[1]),
  .bus_rdata       (bus_rdata),
  .pwrup_req_o     (pwrup_req_o),
  .no_pwrdn_o      (no_pwrdn_o),
  .warm_rst_req_o  (warm_rst_req_o),
  .pwrup_we        (pwrup_we),
  .warm_fire       (warm_fire)
);

// File: tb/test_dbg_pwr_rst_ctl.sv
module test_dbg_pwr_rst_ctl;
  localparam logic [11:0] OFS = 12'h310;

  logic clk = 1'b0;
  logic core_cold_rst_n = 1'b0, core_warm_rst_n = 1'b0, dbg_ext_rst_n = 1'b0;
  logic core_powered = 1'b1, lock_double = 1'b0, lock_os = 1'b0, lock_sw = 1'b0;
  logic invasive_dbg_en = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwrup_req_o, no_pwrdn_o, warm_rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dbg_pwr_rst_ctl i_dbg_pwr_rst_ctl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_status(input logic [4:0] s);
    core_powered = s[0]; lock_double = s[1]; lock_os = s[2];
    lock_sw = s[3]; invasive_dbg_en = s[4];
  endtask

  // Returns at the falling edge after the capturing rising edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic permissive();
    set_status(5'b10001);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    core_cold_rst_n = 1'b1; core_warm_rst_n = 1'b1; dbg_ext_rst_n = 1'b1;
    @(negedge clk);
    // reset state (R3, R4)
    check("R3 reset pwrup", {31'b0, pwrup_req_o}, 32'd0);
    check("R4 reset npd", {31'b0, no_pwrdn_o}, 32'd0);
    check("R5 reset pulse", {31'b0, warm_rst_req_o}, 32'd0);
    bus_rd(OFS, rd);
    check("R1 reset read", rd, 32'd0);

    // Exhaustive sweep: status x low-nibble pattern
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 16; w++) begin
        logic [3:0] wd;
        logic hid, sw, perm, exp_p, exp_n;
        wd = 4'(w);
        permissive();
        bus_wr(OFS, {28'd0, ~wd[3], 2'b00, ~wd[0]});
        @(negedge clk);
        set_status(5'(s));
        hid  = !s[0] || s[1] || s[2];
        sw   = s[3];
        perm = s[0] && !s[1] && !s[2] && !s[3] && s[4];
        bus_wr(OFS, {28'hFFFFFFF, wd});
        check("R5/R6 pulse", {31'b0, warm_rst_req_o}, {31'b0, wd[1] & perm});
        exp_p = sw ? ~wd[3] : wd[3];
        exp_n = (sw || hid) ? ~wd[0] : wd[0];
        check("R3/R8/R9 pwrup", {31'b0, pwrup_req_o}, {31'b0, exp_p});
        check("R7/R8/R9/R10 npd", {31'b0, no_pwrdn_o}, {31'b0, exp_n});
        bus_rd(OFS, rd);
        check("R2/R7 read", rd, {28'd0, exp_p, 2'b00, exp_n & ~hid});
        @(negedge clk);
        check("R5 single cycle", {31'b0, warm_rst_req_o}, 32'd0);
      end
    end

    // R3/R4: resets per domain
    permissive();
    bus_wr(OFS, 32'h8);
    @(negedge clk); core_warm_rst_n = 1'b0; @(negedge clk); core_warm_rst_n = 1'b1;
    check("R3 warm keeps pwrup", {31'b0, pwrup_req_o}, 32'd1);
    check("R4 warm keeps npd", {31'b0, no_pwrdn_o}, 32'd0);
    core_cold_rst_n = 1'b0; @(negedge clk); core_cold_rst_n = 1'b1;
    check("R3 cold keeps pwrup", {31'b0, pwrup_req_o}, 32'd1);
    check("R4 cold loads npd", {31'b0, no_pwrdn_o}, 32'd1);
    dbg_ext_rst_n = 1'b0; @(negedge clk); dbg_ext_rst_n = 1'b1;
    check("R3 debug reset clears", {31'b0, pwrup_req_o}, 32'd0);
    check("R4 debug reset keeps npd", {31'b0, no_pwrdn_o}, 32'd1);
    core_cold_rst_n = 1'b0; @(negedge clk); core_cold_rst_n = 1'b1;
    check("R4 cold loads zero", {31'b0, no_pwrdn_o}, 32'd0);

    // R1: other address, write all ones
    bus_wr(12'h314, 32'hFFFFFFFF);
    check("R1 miss no pulse", {31'b0, warm_rst_req_o}, 32'd0);
    check("R1 miss state", {30'b0, pwrup_req_o, no_pwrdn_o}, 32'd0);
    bus_wr(OFS, 32'h9);
    bus_rd(12'h314, rd);
    check("R1 miss read", rd, 32'd0);
    bus_rd(OFS, rd);
    check("R1 hit read", rd, 32'h9);

    // R11: idle and write cycles drive zero
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = OFS; #1;
    check("R11 idle read", bus_rdata, 32'd0);

    // R10: hidden bit still drives output
    set_status(5'b10000);
    bus_rd(OFS, rd);
    check("R10 hidden read", rd, 32'h8);
    check("R10 output held", {31'b0, no_pwrdn_o}, 32'd1);
    permissive();

    // R5: write coinciding with warm reset gives no pulse
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = OFS; bus_wdata = 32'h2;
    core_warm_rst_n = 1'b0;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; core_warm_rst_n = 1'b1;
    check("R5 write during warm reset", {31'b0, warm_rst_req_o}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule